// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of general-purpose input pins and turns chosen pin activity into a latched interrupt. Each pin can be set up on its own. It can watch for a level, either high or low. It can watch for one edge, either rising or falling. It can also watch for both edges. Three configuration registers make that choice: a sense-type register, a polarity register and a both-edges register. The pin inputs pass through a synchronizer before any sensing.

Detected events set bits in a sticky status register. Software clears those bits by writing ones to them. A mask register decides which status bits reach the single combined interrupt line. Software cannot write the mask directly. It is changed only through two write-only locations: one that unblocks pins and one that blocks them. Masking never stops detection. An event that arrives while a pin is blocked is kept, and it raises the interrupt as soon as the pin is unblocked.

The register port is a simple synchronous write strobe with a combinational read path. It sits behind whatever bus bridge the surrounding subsystem uses.

Top module: `pin_event_detector`

## Requirements
- R1: While reset is low, the mask reads all ones, and status, sense-type, polarity and both-edges all read zero. The interrupt output is low during reset.
- R2: The sense-type register (offset 0x21C), polarity register (0x220) and both-edges register (0x224) read back exactly what was last written to them.
- R3: With type bit 1, both-edges bit 0 and polarity bit 1, a rising pin sets its status bit. A falling pin does not.
- R4: With type bit 1, both-edges bit 0 and polarity bit 0, a falling pin sets its status bit. A rising pin does not.
- R5: With type bit 1 and both-edges bit 1, either edge sets the status bit, whatever the polarity bit holds.
- R6: With type bit 0, the status bit is set while the pin sits at the level given by polarity (1 means high, 0 means low). The both-edges bit has no effect in this mode. If the active level is still present after a clear, the bit sets again.
- R7: Writing to the status register (0x218) clears each bit written as 1 and leaves bits written as 0 unchanged. If a detection event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: Writing 1s to the unblock location (0x210) clears those mask bits. Writing 1s to the block location (0x214) sets them. Zero bits in either write have no effect. The mask (read at 0x20C) ignores direct writes. A mask bit of 1 blocks that pin.
- R9: The interrupt output is high exactly when some pin has its status bit set and its mask bit clear. Detection keeps setting status bits while a pin is masked.
- R10: A pin change driven between clock edges shows in the status register after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Raw pin levels, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Combined interrupt: any status bit that is not masked |

## Verification
A pin change costs two synchronizer edges, and the status flop is loaded on the third edge. The bench therefore drives pins on a falling edge and checks for status both after two rising edges (expecting nothing) and after three (expecting the event). Register writes, mask changes and status clears take effect at the single rising edge that captures the strobe. The interrupt output follows combinationally from the mask and status flops. Every read and interrupt check is therefore taken one nanosecond after the falling edge that follows the write. Level-sensed pins re-arm in the cycle after a clear, so the clear-while-active cases are read one edge after the clear write.

// File: rtl/ped_pkg.sv
package ped_pkg;
   localparam int unsigned OFS_W = 12;
   localparam logic [OFS_W-1:0] OFS_MASK    = 12'h20C;
   localparam logic [OFS_W-1:0] OFS_UNBLOCK = 12'h210;
   localparam logic [OFS_W-1:0] OFS_BLOCK   = 12'h214;
   localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h218;
   localparam logic [OFS_W-1:0] OFS_TYPE    = 12'h21C;
   localparam logic [OFS_W-1:0] OFS_POL     = 12'h220;
   localparam logic [OFS_W-1:0] OFS_BOTH    = 12'h224;
endpackage

// File: rtl/ped_sync.sv
module ped_sync #(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   output logic [NUM_PINS-1:0] sync_o
);
   logic [NUM_PINS-1:0] chain_q [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= pins_i;
         for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/ped_sense.sv
module ped_sense #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] sync_i,
   input  logic [NUM_PINS-1:0] type_i,
   input  logic [NUM_PINS-1:0] pol_i,
   input  logic [NUM_PINS-1:0] both_i,
   output logic [NUM_PINS-1:0] prev_o,
   output logic [NUM_PINS-1:0] event_o
);
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic rise, fall, edge_hit, lvl_hit;
      always_comb begin
         rise     = sync_i[p] & ~prev_q[p];
         fall     = ~sync_i[p] & prev_q[p];
         edge_hit = both_i[p] ? (rise | fall) : (pol_i[p] ? rise : fall);
         lvl_hit  = pol_i[p] ? sync_i[p] : ~sync_i[p];
         event_o[p] = type_i[p] ? edge_hit : lvl_hit;
      end
   end

   assign prev_o = prev_q;
endmodule

// File: rtl/ped_regs.sv
module ped_regs
   import ped_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] event_i,
   output logic [NUM_PINS-1:0] type_o,
   output logic [NUM_PINS-1:0] pol_o,
   output logic [NUM_PINS-1:0] both_o,
   output logic [NUM_PINS-1:0] mask_o,
   output logic [NUM_PINS-1:0] status_o,
   output logic                irq_o
);
   logic [NUM_PINS-1:0] wbits;
   logic [NUM_PINS-1:0] type_q, pol_q, both_q, mask_q, status_q;
   logic [NUM_PINS-1:0] unblock_w, block_w, clear_w;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign wbits     = bus_wdata[NUM_PINS-1:0];
   assign unblock_w = (bus_wr && hit(bus_addr, OFS_UNBLOCK)) ? wbits : '0;
   assign block_w   = (bus_wr && hit(bus_addr, OFS_BLOCK))   ? wbits : '0;
   assign clear_w   = (bus_wr && hit(bus_addr, OFS_STATUS))  ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q   <= '0;
         pol_q    <= '0;
         both_q   <= '0;
         mask_q   <= '1;
         status_q <= '0;
      end else begin
         if (bus_wr && hit(bus_addr, OFS_TYPE)) type_q <= wbits;
         if (bus_wr && hit(bus_addr, OFS_POL))  pol_q  <= wbits;
         if (bus_wr && hit(bus_addr, OFS_BOTH)) both_q <= wbits;
         mask_q   <= (mask_q & ~unblock_w) | block_w;
         status_q <= (status_q & ~clear_w) | event_i;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if      (hit(bus_addr, OFS_MASK))   bus_rdata = DATA_W'(mask_q);
      else if (hit(bus_addr, OFS_STATUS)) bus_rdata = DATA_W'(status_q);
      else if (hit(bus_addr, OFS_TYPE))   bus_rdata = DATA_W'(type_q);
      else if (hit(bus_addr, OFS_POL))    bus_rdata = DATA_W'(pol_q);
      else if (hit(bus_addr, OFS_BOTH))   bus_rdata = DATA_W'(both_q);
   end

   assign irq_o    = |(status_q & ~mask_q);
   assign type_o   = type_q;
   assign pol_o    = pol_q;
   assign both_o   = both_q;
   assign mask_o   = mask_q;
   assign status_o = status_q;
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
   import ped_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_o
);
   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must lie between 1 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   logic [NUM_PINS-1:0] sync_w, prev_w, event_w;
   logic [NUM_PINS-1:0] type_w, pol_w, both_w, mask_w, status_w;

   ped_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sync_o(sync_w)
   );

   ped_sense #(.NUM_PINS(NUM_PINS)) u_sense (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_w),
      .type_i(type_w), .pol_i(pol_w), .both_i(both_w),
      .prev_o(prev_w), .event_o(event_w)
   );

   ped_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .event_i(event_w),
      .type_o(type_w), .pol_o(pol_w), .both_o(both_w),
      .mask_o(mask_w), .status_o(status_w), .irq_o(irq_o)
   );
endmodule

// File: rtl/pin_event_checker.sv
module pin_event_checker
   import ped_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] sync_w,
   input logic [NUM_PINS-1:0] prev_w,
   input logic [NUM_PINS-1:0] event_w,
   input logic [NUM_PINS-1:0] type_w,
   input logic [NUM_PINS-1:0] mask_w,
   input logic [NUM_PINS-1:0] status_w
);
   logic wr_unblock, wr_block, wr_status;
   assign wr_unblock = bus_wr && bus_addr == ADDR_W'(OFS_UNBLOCK);
   assign wr_block   = bus_wr && bus_addr == ADDR_W'(OFS_BLOCK);
   assign wr_status  = bus_wr && bus_addr == ADDR_W'(OFS_STATUS);

   AST_UNBLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_unblock |=> (mask_w & $past(bus_wdata[NUM_PINS-1:0])) == '0); // R8
   AST_BLOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_block |=> (mask_w & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])); // R8
   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_unblock || wr_block) |=> $stable(mask_w)); // R8
   AST_STATUS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_w & ~$past(status_w)) & ~$past(event_w)) == '0); // R9
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_w & $past(event_w)) == $past(event_w)); // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_status |=> (status_w & $past(bus_wdata[NUM_PINS-1:0] & ~event_w)) == '0); // R7
   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (event_w & type_w & ~(sync_w ^ prev_w)) == '0); // R3
   AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_w) |-> !irq_o); // R9
endmodule

bind pin_event_detector pin_event_checker #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq_o(irq_o), .sync_w(sync_w), .prev_w(prev_w),
   .event_w(event_w), .type_w(type_w), .mask_w(mask_w), .status_w(status_w)
);

// File: tb/test_pin_event_detector.sv
`timescale 1ns/1ps
module test_pin_event_detector;
   localparam logic [11:0] A_MASK = 12'h20C, A_UNBLK = 12'h210, A_BLK = 12'h214,
                           A_STS = 12'h218, A_TYPE = 12'h21C, A_POL = 12'h220,
                           A_BOTH = 12'h224;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;
   logic [31:0] ty, po, an;

   always #4 clk = ~clk;

   pin_event_detector i_pin_event_detector (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic irq_chk(input string req, input logic exp);
      #1;
      chk(req, {31'd0, irq_o}, {31'd0, exp});
   endtask

   task automatic t_reset;
      #20;
      rd_chk("R1 mask", A_MASK, 32'hFFFF_FFFF);
      rd_chk("R1 status", A_STS, 32'h0);
      rd_chk("R1 type", A_TYPE, 32'h0);
      rd_chk("R1 polarity", A_POL, 32'h0);
      rd_chk("R1 both", A_BOTH, 32'h0);
      irq_chk("R1 irq", 1'b0);
      @(negedge clk); rst_n = 1'b1; tick(1);
   endtask

   task automatic t_regs;
      wr(A_TYPE, 32'hA5A5_0F0F); rd_chk("R2 type", A_TYPE, 32'hA5A5_0F0F);
      wr(A_POL,  32'h1234_5678); rd_chk("R2 polarity", A_POL, 32'h1234_5678);
      wr(A_BOTH, 32'hF00D_C0DE); rd_chk("R2 both", A_BOTH, 32'hF00D_C0DE);
      ty = '1; po = '1; an = '0;
      wr(A_TYPE, ty); wr(A_POL, po); wr(A_BOTH, an);
      wr(A_STS, 32'hFFFF_FFFF); tick(1);
      rd_chk("R7 clear all", A_STS, 32'h0);
   endtask

   task automatic t_rise;
      pins[3] = 1'b1; tick(2);
      rd_chk("R10 not after two edges", A_STS, 32'h0);
      tick(1);
      rd_chk("R10/R3 rising sets", A_STS, 32'h8);
      wr(A_STS, 32'h8);
      pins[3] = 1'b0; tick(4);
      rd_chk("R3 falling ignored", A_STS, 32'h0);
   endtask

   task automatic t_fall;
      po[5] = 1'b0; wr(A_POL, po);
      pins[5] = 1'b1; tick(4);
      rd_chk("R4 rising ignored", A_STS, 32'h0);
      pins[5] = 1'b0; tick(4);
      rd_chk("R4 falling sets", A_STS, 32'h20);
   endtask

   task automatic t_both;
      an[7] = 1'b1; wr(A_BOTH, an);
      pins[7] = 1'b1; tick(4);
      rd_chk("R5 rise sets", A_STS, 32'hA0);
      wr(A_STS, 32'h80);
      pins[7] = 1'b0; tick(4);
      rd_chk("R5 fall sets", A_STS, 32'hA0);
      wr(A_STS, 32'h80); tick(1);
      rd_chk("R5 cleared", A_STS, 32'h20);
   endtask

   task automatic t_level;
      an[9] = 1'b1; wr(A_BOTH, an);
      ty[9] = 1'b0; wr(A_TYPE, ty);
      pins[9] = 1'b1; tick(4);
      rd_chk("R6 high level sets", A_STS, 32'h220);
      wr(A_STS, 32'h200);
      rd_chk("R7 event beats clear", A_STS, 32'h220);
      pins[9] = 1'b0; tick(4);
      wr(A_STS, 32'h200); tick(2);
      rd_chk("R6 both-edges ignored when level", A_STS, 32'h20);
      po[10] = 1'b0; wr(A_POL, po);
      ty[10] = 1'b0; wr(A_TYPE, ty); tick(1);
      rd_chk("R6 low level sets", A_STS, 32'h420);
      wr(A_STS, 32'h400); tick(1);
      rd_chk("R6 re-set after clear", A_STS, 32'h420);
      po[10] = 1'b1; wr(A_POL, po);
      ty[10] = 1'b1; wr(A_TYPE, ty);
      wr(A_STS, 32'h400); tick(1);
      rd_chk("R6 restored", A_STS, 32'h20);
   endtask

   task automatic t_w1c;
      wr(A_STS, 32'h0);
      rd_chk("R7 zeros keep", A_STS, 32'h20);
   endtask

   task automatic t_mask;
      irq_chk("R9 pending but masked", 1'b0);
      wr(A_MASK, 32'h0);
      rd_chk("R8 direct write ignored", A_MASK, 32'hFFFF_FFFF);
      wr(A_UNBLK, 32'h0);
      rd_chk("R8 zero unblock", A_MASK, 32'hFFFF_FFFF);
      wr(A_UNBLK, 32'h20);
      rd_chk("R8 unblock clears", A_MASK, 32'hFFFF_FFDF);
      irq_chk("R9 irq on unblock", 1'b1);
      wr(A_BLK, 32'h0);
      rd_chk("R8 zero block", A_MASK, 32'hFFFF_FFDF);
      wr(A_BLK, 32'h20);
      rd_chk("R8 block sets", A_MASK, 32'hFFFF_FFFF);
      irq_chk("R9 irq blocked", 1'b0);
      pins[3] = 1'b1; tick(4);
      rd_chk("R9 detect while masked", A_STS, 32'h28);
      irq_chk("R9 still quiet", 1'b0);
      wr(A_UNBLK, 32'h8);
      irq_chk("R9 latched event shows", 1'b1);
      wr(A_STS, 32'h8);
      irq_chk("R9 irq after clear", 1'b0);
      wr(A_STS, 32'h20);
      rd_chk("R7 final clear", A_STS, 32'h0);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_rise();
      t_fall();
      t_both();
      t_level();
      t_w1c();
      t_mask();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule